// File: doc/BRIEF.md
# Link-Layer Replay Buffer Controller

This block is the transmit-side packet store of a packet link layer. Packets from the upper layer arrive on a valid/ready stream, each one payload word plus a 32-bit link CRC word that is computed elsewhere. The block tags every accepted packet with a 12-bit sequence number and keeps it until the far end acknowledges it. It also sends each packet once to the lower layer, which sees a valid/ready stream carrying sequence number, payload and CRC.

Acknowledge information comes back on a sideband port: a strobe, an ACK/NAK select bit and the 12-bit sequence number that the peer reports. An ACK frees every stored packet up to and including that number. A NAK frees the same packets and then re-sends the rest from the oldest. A separate request input starts the same re-send without freeing anything, for use by an external timeout. The block flags full and empty. A low link-active input returns all sequence state to its initial values.

Top module: `replay_buf_ctrl`

## Requirements
- R1: While `link_up` is low, and after reset, the block holds no packets: `empty`=1, `full`=0, `out_valid`=0. The first packet accepted afterwards gets sequence number 0.
- R2: Each accepted packet (`in_valid` and `in_ready` high at a clock edge) gets the sequence number one above the previous one, modulo 4096. So 4095 is followed by 0.
- R3: Every accepted packet is offered once on the output, in acceptance order, with its own sequence number, payload and CRC. Each output handshake moves `out_seq` on by exactly one. `out_valid` is 0 whenever `empty` is 1.
- R4: `full` is 1 when the stored count reaches 2^AW, or 2048 if that is smaller. While `full` is 1, `in_ready` is 0.
- R5: An accepted ACK with number `a` removes every stored packet up to and including `a`. When `a` is the newest stored number, `empty` becomes 1.
- R6: An accepted NAK with number `a` removes the same packets as an ACK. The output then restarts at `a`+1 and sends every remaining stored packet again, in sequence order.
- R7: A pulse on `replay_req` restarts the output at the oldest stored packet and sends all stored packets again in order. Nothing is removed.
- R8: From the start of a replay until the newest stored packet has been sent again, `in_ready` is 0.
- R9: An ACK/NAK number `a` is accepted only if (a − last) mod 4096 is no greater than the stored count, where `last` is the last accepted number (4095 after reset). Any other number is ignored: nothing is removed and no replay starts.
- R10: An ACK that covers packets not yet sent removes them, and the output skips to the first packet after `a`.
- R11: A number equal to `last` is accepted and removes nothing. As a NAK it replays every stored packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link layer active; low clears sequence state |
| in_valid | input | 1 | Upper-layer packet valid |
| in_ready | output | 1 | Block can accept a packet |
| in_data | input | DATA_W | Packet payload word |
| in_crc | input | 32 | Link CRC of the packet |
| out_valid | output | 1 | Packet offered to lower layer |
| out_ready | input | 1 | Lower layer takes the packet |
| out_seq | output | 12 | Sequence number of offered packet |
| out_data | output | DATA_W | Payload of offered packet |
| out_crc | output | 32 | Link CRC of offered packet |
| ack_valid | input | 1 | Acknowledge report strobe |
| ack_is_nak | input | 1 | 1 = NAK, 0 = ACK |
| ack_seq | input | 12 | Sequence number reported by the peer |
| replay_req | input | 1 | Request to re-send all stored packets |
| full | output | 1 | Store at capacity |
| empty | output | 1 | No stored packets |

## Verification
The bench builds the block with AW=2, a four-entry store. The full flag, the stall of the input while full, and every acknowledge and replay case therefore appear within a few dozen packets. The small store does not limit the sequence numbers, so a stream of more than 4096 acknowledged packets takes the counter across the 4095-to-0 wrap while the buffer index keeps cycling through its four slots. Out-of-window and backward acknowledge numbers, a duplicate NAK, and an ACK that runs ahead of the output are all checked against the offered sequence number that follows them.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
    localparam int SEQ_W = 12;
    typedef logic [SEQ_W-1:0] seq_t;

    // Sequence state of the controller
    typedef struct packed {
        seq_t next_seq;   // number given to the next accepted packet
        seq_t ackd_seq;   // last accepted acknowledge number
        seq_t send_seq;   // number of the packet offered next
        logic replay;     // replay in progress
    } state_t;

    localparam state_t STATE_RST = '{next_seq: '0, ackd_seq: '1, send_seq: '0, replay: 1'b0};
endpackage

// File: rtl/rbc_ack_filter.sv
module rbc_ack_filter
    import rbc_pkg::*;
(
    input  seq_t ackd_seq,
    input  seq_t next_seq,
    input  seq_t ack_seq,
    output logic ack_ok,
    output seq_t purge_cnt,
    output seq_t occupancy
);
    // Stored packets run from ackd_seq+1 to next_seq-1, modulo 4096
    assign occupancy = next_seq - ackd_seq - 12'd1;
    assign purge_cnt = ack_seq - ackd_seq;
    // Forward and within the stored range; this also excludes backward moves
    assign ack_ok    = (purge_cnt <= occupancy);
endmodule

// File: rtl/rbc_flags.sv
module rbc_flags
    import rbc_pkg::*;
#(
    parameter int AW = 3
) (
    input  seq_t occupancy,
    output logic full,
    output logic empty
);
    localparam int   DEPTH   = 1 << AW;
    localparam int   CAP     = (DEPTH < 2048) ? DEPTH : 2048;
    localparam seq_t CAP_SEQ = seq_t'(CAP);

    assign full  = (occupancy >= CAP_SEQ);
    assign empty = (occupancy == '0);
endmodule

// File: rtl/rbc_store.sv
module rbc_store #(
    parameter int DATA_W = 32,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [31:0]       wcrc,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [31:0]       rcrc
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [31:0]       crc_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            data_mem[waddr] <= wdata;
            crc_mem[waddr]  <= wcrc;
        end
    end

    assign rdata = data_mem[raddr];
    assign rcrc  = crc_mem[raddr];
endmodule

// File: rtl/replay_buf_ctrl.sv
module replay_buf_ctrl
    import rbc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 3    // store holds 2**AW packets, AW at most 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [31:0]       in_crc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [11:0]       out_seq,
    output logic [DATA_W-1:0] out_data,
    output logic [31:0]       out_crc,
    input  logic              ack_valid,
    input  logic              ack_is_nak,
    input  logic [11:0]       ack_seq,
    input  logic              replay_req,
    output logic              full,
    output logic              empty
);
    state_t state_q, state_d;
    seq_t   occupancy, purge_cnt;
    seq_t   head_new, send_off;
    logic   ack_ok, in_fire, out_fire;

    rbc_ack_filter u_filter (
        .ackd_seq  (state_q.ackd_seq),
        .next_seq  (state_q.next_seq),
        .ack_seq   (ack_seq),
        .ack_ok    (ack_ok),
        .purge_cnt (purge_cnt),
        .occupancy (occupancy)
    );

    rbc_flags #(.AW(AW)) u_flags (
        .occupancy (occupancy),
        .full      (full),
        .empty     (empty)
    );

    rbc_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
        .clk   (clk),
        .we    (in_fire),
        .waddr (state_q.next_seq[AW-1:0]),
        .wdata (in_data),
        .wcrc  (in_crc),
        .raddr (state_q.send_seq[AW-1:0]),
        .rdata (out_data),
        .rcrc  (out_crc)
    );

    assign in_ready  = link_up && !full && !state_q.replay;
    assign out_valid = (state_q.send_seq != state_q.next_seq);
    assign out_seq   = state_q.send_seq;
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;

    always_comb begin
        state_d  = state_q;
        head_new = state_q.ackd_seq + 12'd1;
        send_off = '0;

        if (out_fire) state_d.send_seq = state_q.send_seq + 12'd1;
        if (in_fire)  state_d.next_seq = state_q.next_seq + 12'd1;

        if (ack_valid && ack_ok) begin
            state_d.ackd_seq = ack_seq;
            head_new         = ack_seq + 12'd1;
            // Packets purged before being sent are skipped
            send_off = state_d.send_seq - state_q.ackd_seq - 12'd1;
            if (send_off < purge_cnt) state_d.send_seq = head_new;
            if (ack_is_nak) begin
                state_d.send_seq = head_new;
                state_d.replay   = 1'b1;
            end
        end

        if (replay_req) begin
            state_d.send_seq = head_new;
            state_d.replay   = 1'b1;
        end

        if (state_d.send_seq == state_d.next_seq) state_d.replay = 1'b0;

        if (!link_up) state_d = STATE_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STATE_RST;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        link_up,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [11:0] out_seq,
    input logic        ack_valid,
    input logic        ack_is_nak,
    input logic [11:0] ack_seq,
    input logic        ack_ok,
    input logic        replay_req,
    input logic        replay_q,
    input logic [11:0] ackd_q,
    input logic        full,
    input logic        empty
);
    AST_INACTIVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (empty && !out_valid && !full)); // R1

    AST_OUT_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && out_valid && out_ready && !ack_valid && !replay_req)
        |=> (out_seq == $past(out_seq) + 12'd1)); // R3

    AST_EMPTY_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !out_valid); // R3

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !in_ready); // R4

    AST_NAK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && ack_valid && ack_ok && ack_is_nak)
        |=> (out_seq == $past(ack_seq) + 12'd1)); // R6

    AST_REPLAY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && replay_req && !ack_valid)
        |=> (out_seq == $past(ackd_q) + 12'd1)); // R7

    AST_REPLAY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        replay_q |-> !in_ready); // R8

    AST_BAD_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && ack_valid && !ack_ok) |=> (ackd_q == $past(ackd_q))); // R9
endmodule

bind replay_buf_ctrl rbc_checker u_rbc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_seq    (out_seq),
    .ack_valid  (ack_valid),
    .ack_is_nak (ack_is_nak),
    .ack_seq    (ack_seq),
    .ack_ok     (ack_ok),
    .replay_req (replay_req),
    .replay_q   (state_q.replay),
    .ackd_q     (state_q.ackd_seq),
    .full       (full),
    .empty      (empty)
);

// File: tb/replay_buf_ctrl_bench.sv
module replay_buf_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int AW         = 2;

    localparam logic [2:0] OP_PUSH  = 3'd0;
    localparam logic [2:0] OP_POP   = 3'd1;
    localparam logic [2:0] OP_ACK   = 3'd2;
    localparam logic [2:0] OP_NAK   = 3'd3;
    localparam logic [2:0] OP_RPLY  = 3'd4;
    localparam logic [2:0] OP_READY = 3'd5;

    // Row: {op, value, expected empty, expected full}
    localparam int NROWS = 29;
    localparam logic [16:0] TBL [NROWS] = '{
        {OP_PUSH,  12'd0,   2'b00},
        {OP_PUSH,  12'd1,   2'b00},
        {OP_POP,   12'd0,   2'b00},
        {OP_POP,   12'd1,   2'b00},
        {OP_PUSH,  12'd2,   2'b00},
        {OP_PUSH,  12'd3,   2'b01},  // R4 four stored
        {OP_READY, 12'd0,   2'b01},  // R4 stalled while full
        {OP_ACK,   12'd1,   2'b00},  // R5
        {OP_POP,   12'd2,   2'b00},
        {OP_NAK,   12'd2,   2'b00},  // R6 restart at 3
        {OP_READY, 12'd0,   2'b00},  // R8 stalled in replay
        {OP_POP,   12'd3,   2'b00},
        {OP_READY, 12'd1,   2'b00},  // R8 replay over
        {OP_RPLY,  12'd0,   2'b00},  // R7
        {OP_POP,   12'd3,   2'b00},
        {OP_ACK,   12'd3,   2'b10},  // R5 all acknowledged
        {OP_ACK,   12'd100, 2'b10},  // R9 out of window
        {OP_PUSH,  12'd4,   2'b00},
        {OP_ACK,   12'd2,   2'b00},  // R9 backward
        {OP_RPLY,  12'd0,   2'b00},
        {OP_POP,   12'd4,   2'b00},  // R9 oldest still 4
        {OP_NAK,   12'd3,   2'b00},  // R11 duplicate NAK
        {OP_POP,   12'd4,   2'b00},
        {OP_ACK,   12'd4,   2'b10},
        {OP_PUSH,  12'd5,   2'b00},
        {OP_PUSH,  12'd6,   2'b00},
        {OP_ACK,   12'd5,   2'b00},  // R10 covers unsent 5
        {OP_POP,   12'd6,   2'b00},
        {OP_ACK,   12'd6,   2'b10}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              link_up = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic [31:0]       in_crc = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [11:0]       out_seq;
    logic [DATA_W-1:0] out_data;
    logic [31:0]       out_crc;
    logic              ack_valid = 1'b0;
    logic              ack_is_nak = 1'b0;
    logic [11:0]       ack_seq = '0;
    logic              replay_req = 1'b0;
    logic              full, empty;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    replay_buf_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_replay_buf_ctrl (
        .clk, .rst_n, .link_up, .in_valid, .in_ready, .in_data, .in_crc,
        .out_valid, .out_ready, .out_seq, .out_data, .out_crc,
        .ack_valid, .ack_is_nak, .ack_seq, .replay_req, .full, .empty
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [DATA_W-1:0] d, input string req);
        chk(in_ready == 1'b1, req, "in_ready before push", in_ready, 1);
        in_valid = 1'b1;
        in_data  = d;
        in_crc   = ~d;
        step();
        in_valid = 1'b0;
    endtask

    task automatic pop(input logic [11:0] s, input logic [DATA_W-1:0] d, input string req);
        chk(out_valid == 1'b1, req, "out_valid", out_valid, 1);
        chk(out_seq == s, req, "out_seq", out_seq, s);
        chk(out_data == d, req, "out_data", out_data, d);
        chk(out_crc == ~d, req, "out_crc", out_crc, ~d);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
    endtask

    task automatic report(input logic [11:0] s, input bit nak);
        ack_valid  = 1'b1;
        ack_is_nak = nak;
        ack_seq    = s;
        step();
        ack_valid  = 1'b0;
        ack_is_nak = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(empty == 1'b1, "R1", "empty after reset", empty, 1);
        chk(full == 1'b0, "R1", "full after reset", full, 0);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        for (int r = 0; r < NROWS; r++) begin
            logic [2:0]  op;
            logic [11:0] v;
            string       req;
            op = TBL[r][16:14];
            v  = TBL[r][13:2];
            case (op)
                OP_PUSH:  req = "R2";
                OP_POP:   req = "R3";
                OP_ACK:   req = "R5";
                OP_NAK:   req = "R6";
                OP_RPLY:  req = "R7";
                default:  req = "R8";
            endcase
            case (op)
                OP_PUSH:  push(DATA_W'(32'h100 + v), req);
                OP_POP:   pop(v, DATA_W'(32'h100 + v), req);
                OP_ACK:   report(v, 1'b0);
                OP_NAK:   report(v, 1'b1);
                OP_RPLY: begin
                    replay_req = 1'b1;
                    step();
                    replay_req = 1'b0;
                end
                default:  chk(in_ready == v[0], req, "in_ready", in_ready, v[0]);
            endcase
            chk(empty == TBL[r][1], req, $sformatf("empty row %0d", r), empty, TBL[r][1]);
            chk(full == TBL[r][0], req, $sformatf("full row %0d", r), full, TBL[r][0]);
        end

        // R2 wrap of the sequence number; next number is 7 here
        begin
            int bad = 0;
            for (int i = 0; i < 4100; i++) begin
                logic [11:0] es;
                es = 12'(7 + i);
                if (!in_ready) bad++;
                in_valid = 1'b1;
                in_data  = DATA_W'(i);
                in_crc   = ~DATA_W'(i);
                step();
                in_valid = 1'b0;
                if (i == 4088) chk(out_seq == 12'd4095, "R2", "seq before wrap", out_seq, 4095);
                if (i == 4089) chk(out_seq == 12'd0, "R2", "seq after wrap", out_seq, 0);
                if (!out_valid || out_seq != es || out_data != DATA_W'(i)) bad++;
                out_ready = 1'b1;
                step();
                out_ready = 1'b0;
                report(es, 1'b0);
                if (!empty) bad++;
            end
            chk(bad == 0, "R2", "stream mismatches", bad, 0);
        end

        // R1 link inactive clears everything
        push(DATA_W'(32'h55), "R1");
        push(DATA_W'(32'h66), "R1");
        link_up = 1'b0;
        step();
        chk(empty == 1'b1, "R1", "empty while inactive", empty, 1);
        chk(out_valid == 1'b0, "R1", "out_valid while inactive", out_valid, 0);
        link_up = 1'b1;
        step();
        push(DATA_W'(32'h77), "R1");
        pop(12'd0, DATA_W'(32'h77), "R1");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule